// File: doc/BRIEF.md
# Guarded Register Commit Sequencer

This block sits behind a host transaction port and protects a bank of clock and control registers against stray writes. A host opens a transaction with a start pulse, issues any number of addressed write strobes, and closes it with a stop pulse. Write data never goes straight into the protected bank. It is collected in a holding buffer, and the bank takes the buffered values only at a valid stop, and only when a two-step unlock held in a status register is complete.

The unlock uses two volatile latch bits. A first status code arms the write-enable latch. A second code, accepted only while that latch is armed, sets the register-enable latch. A clearing code drops both. Each committed write models a slow non-volatile programming cycle as a busy interval of programmable length. New transactions are refused during that interval. A transaction that is cut short by a fresh start, with no stop, loses its buffered data.

Top module: `guarded_reg_commit`

## Requirements
- R1: After reset all protected registers read zero, both latch bits are clear and busy is low.
- R2: A status write of code 0x02 to address NREG (default 8), applied at the valid stop, sets the write-enable latch, which is latch_state bit 0.
- R3: A status write of code 0x06 sets the register-enable latch (latch_state bit 1) only when the write-enable latch was already set before that stop. While the write-enable latch is clear, the code has no effect.
- R4: Status code 0x00 clears both latch bits. Any other status code leaves them unchanged.
- R5: Writes to addresses 0 to NREG-1 are buffered. At the stop edge, and only if the register-enable latch is set, every buffered register is copied into the bank together, and the last write to an address wins. Register i appears at reg_flat[i*DW +: DW]. With the latch clear, the buffer is discarded.
- R6: A start that arrives while a transaction is open discards everything that transaction had buffered.
- R7: A stop that commits at least one register raises busy from the next cycle for exactly busy_len cycles. A busy_len of 0 gives no busy cycle.
- R8: txn_ack is high for a start only while busy is low. A start refused while busy opens no transaction, so its writes and its stop change nothing.
- R9: Write strobes outside an accepted transaction, strobes in the same cycle as a start or a stop, and strobes to addresses above NREG are ignored.
- R10: When one transaction writes both protected registers and the status register, the commit decision uses the latch state from before that stop, and the status code is applied afterwards. The register-enable latch is never set while the write-enable latch is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| txn_start | input | 1 | Opens a write transaction (pulse) |
| txn_stop | input | 1 | Closes the open transaction (pulse) |
| wr_valid | input | 1 | Write strobe |
| wr_addr | input | AW | Write address; NREG selects the status register |
| wr_data | input | DW | Write data |
| busy_len | input | BW | Length of the modelled programming cycle in clocks |
| txn_ack | output | 1 | Start accepted |
| busy | output | 1 | Programming cycle in progress |
| latch_state | output | 2 | {register-enable, write-enable} latch bits |
| reg_flat | output | NREG*DW | Committed protected register contents |

## Verification
The bench goes after the unlock order. It sends the second code before the first, which a design that ignores the ordering would wrongly accept. It sends an unknown code, which a loose decoder might treat as a clear. It aborts a transaction with a second start, which a design that does not flush the buffer on that start would leak into a later commit. It times the busy window cycle by cycle, which exposes an off-by-one count, and it writes during busy, which a design that still acknowledges would commit. A mixed transaction checks that the commit uses the old latch state even though the same stop clears the latches.

// File: rtl/grc_pkg.sv
package grc_pkg;

  localparam logic [7:0] CODE_CLEAR  = 8'h00;
  localparam logic [7:0] CODE_ARM    = 8'h02;
  localparam logic [7:0] CODE_UNLOCK = 8'h06;

  typedef struct packed {
    logic reg_en;
    logic wr_en;
  } latch_t;

  // Next latch state for a status code applied at a valid stop.
  function automatic latch_t latch_next(input logic [7:0] code, input latch_t cur);
    latch_t n;
    n = cur;
    case (code)
      CODE_CLEAR:  n = '0;
      CODE_ARM:    n.wr_en = 1'b1;
      CODE_UNLOCK: if (cur.wr_en) n.reg_en = 1'b1;
      default:     n = cur;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/grc_txn_tracker.sv
module grc_txn_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic txn_start,
  input  logic txn_stop,
  input  logic busy,
  output logic in_txn,
  output logic start_ok,
  output logic stop_ok,
  output logic abort
);

  assign start_ok = txn_start & ~busy;
  assign stop_ok  = txn_stop & in_txn;
  assign abort    = start_ok & in_txn & ~txn_stop;

  always_ff @(posedge clk) begin
    if (!rst_n)        in_txn <= 1'b0;
    else if (start_ok) in_txn <= 1'b1;
    else if (stop_ok)  in_txn <= 1'b0;
  end

endmodule

// File: rtl/grc_write_buffer.sv
module grc_write_buffer #(
  parameter int NREG = 8,
  parameter int DW   = 8,
  parameter int AW   = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clear,
  input  logic                     wr_take,
  input  logic [AW-1:0]            wr_addr,
  input  logic [DW-1:0]            wr_data,
  output logic [NREG-1:0][DW-1:0]  buf_data,
  output logic [NREG-1:0]          dirty,
  output logic                     st_pend,
  output logic [7:0]               st_code
);

  localparam logic [AW-1:0] STATUS_ADDR = AW'(NREG);

  for (genvar i = 0; i < NREG; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        dirty[i]    <= 1'b0;
        buf_data[i] <= '0;
      end else if (clear) begin
        dirty[i]    <= 1'b0;
      end else if (wr_take && wr_addr == AW'(i)) begin
        dirty[i]    <= 1'b1;
        buf_data[i] <= wr_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_pend <= 1'b0;
      st_code <= '0;
    end else if (clear) begin
      st_pend <= 1'b0;
    end else if (wr_take && wr_addr == STATUS_ADDR) begin
      st_pend <= 1'b1;
      st_code <= wr_data[7:0];
    end
  end

endmodule

// File: rtl/grc_busy_timer.sv
module grc_busy_timer #(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [BW-1:0] len,
  output logic          busy
);

  logic [BW-1:0] remain;

  always_ff @(posedge clk) begin
    if (!rst_n)              remain <= '0;
    else if (load)           remain <= len;
    else if (remain != '0)   remain <= remain - 1'b1;
  end

  assign busy = (remain != '0);

endmodule

// File: rtl/guarded_reg_commit.sv
module guarded_reg_commit
  import grc_pkg::*;
#(
  parameter int NREG = 8,
  parameter int DW   = 8,
  parameter int AW   = 4,
  parameter int BW   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               txn_start,
  input  logic               txn_stop,
  input  logic               wr_valid,
  input  logic [AW-1:0]      wr_addr,
  input  logic [DW-1:0]      wr_data,
  input  logic [BW-1:0]      busy_len,
  output logic               txn_ack,
  output logic               busy,
  output logic [1:0]         latch_state,
  output logic [NREG*DW-1:0] reg_flat
);

  // Named internal events
  logic                    in_txn, start_ok, stop_ok, abort;
  logic                    wr_take, commit_fire, latch_fire;
  logic [NREG-1:0][DW-1:0] buf_data;
  logic [NREG-1:0]         dirty;
  logic                    st_pend;
  logic [7:0]              st_code;
  latch_t                  latch_q;
  logic [NREG-1:0][DW-1:0] bank;

  grc_txn_tracker u_trk (
    .clk(clk), .rst_n(rst_n), .txn_start(txn_start), .txn_stop(txn_stop),
    .busy(busy), .in_txn(in_txn), .start_ok(start_ok), .stop_ok(stop_ok),
    .abort(abort)
  );

  assign wr_take = wr_valid & in_txn & ~txn_start & ~txn_stop;

  grc_write_buffer #(.NREG(NREG), .DW(DW), .AW(AW)) u_buf (
    .clk(clk), .rst_n(rst_n), .clear(start_ok | stop_ok), .wr_take(wr_take),
    .wr_addr(wr_addr), .wr_data(wr_data), .buf_data(buf_data), .dirty(dirty),
    .st_pend(st_pend), .st_code(st_code)
  );

  assign commit_fire = stop_ok & latch_q.reg_en & (|dirty);
  assign latch_fire  = stop_ok & st_pend;

  grc_busy_timer #(.BW(BW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(commit_fire), .len(busy_len), .busy(busy)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)          latch_q <= '0;
    else if (latch_fire) latch_q <= latch_next(st_code, latch_q);
  end

  for (genvar i = 0; i < NREG; i++) begin : g_bank
    always_ff @(posedge clk) begin
      if (!rst_n)                        bank[i] <= '0;
      else if (commit_fire && dirty[i])  bank[i] <= buf_data[i];
    end
    assign reg_flat[i*DW +: DW] = bank[i];
  end

  assign txn_ack     = start_ok;
  assign latch_state = {latch_q.reg_en, latch_q.wr_en};

endmodule

// File: rtl/grc_checker.sv
module grc_checker #(
  parameter int NREG = 8,
  parameter int DW   = 8,
  parameter int BW   = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               txn_ack,
  input logic               busy,
  input logic [1:0]         latch_state,
  input logic [NREG*DW-1:0] reg_flat,
  input logic [BW-1:0]      busy_len,
  input logic               commit_fire,
  input logic               stop_ok,
  input logic               abort,
  input logic [NREG-1:0]    dirty,
  input logic               st_pend,
  input logic [7:0]         st_code
);

  p_reg_implies_wr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    latch_state[1] |-> latch_state[0]);

  p_hold_bank_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_fire |=> $stable(reg_flat));

  p_busy_nack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !txn_ack);

  p_busy_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_fire && busy_len != '0) |=> busy);

  p_abort_flush_r6: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (dirty == '0 && !st_pend));

  p_unlock_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_ok && st_pend && st_code == 8'h06 && !latch_state[0]) |=> !latch_state[1]);

  p_busy_latch_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(latch_state));

endmodule

bind guarded_reg_commit grc_checker #(.NREG(NREG), .DW(DW), .BW(BW)) u_chk (
  .clk(clk), .rst_n(rst_n), .txn_ack(txn_ack), .busy(busy),
  .latch_state(latch_state), .reg_flat(reg_flat), .busy_len(busy_len),
  .commit_fire(commit_fire), .stop_ok(stop_ok), .abort(abort),
  .dirty(dirty), .st_pend(st_pend), .st_code(st_code)
);

// File: tb/guarded_reg_commit_tb.sv
module guarded_reg_commit_tb;
  localparam int NREG = 8, DW = 8, AW = 4, BW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic txn_start = 0, txn_stop = 0, wr_valid = 0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [BW-1:0] busy_len = 8'd6;
  logic txn_ack, busy;
  logic [1:0] latch_state;
  logic [NREG*DW-1:0] reg_flat;

  always #2 clk = ~clk;

  guarded_reg_commit #(.NREG(NREG), .DW(DW), .AW(AW), .BW(BW)) u_dut (
    .clk(clk), .rst_n(rst_n), .txn_start(txn_start), .txn_stop(txn_stop),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy_len(busy_len), .txn_ack(txn_ack), .busy(busy),
    .latch_state(latch_state), .reg_flat(reg_flat)
  );

  int n_chk = 0, n_err = 0;

  typedef struct {
    string              tag;
    logic [NREG*DW-1:0] regs;
    logic [1:0]         lat;
    bit                 use_busy;
    logic               bsy;
  } exp_t;
  exp_t sb[$];

  // Reference model state
  logic [DW-1:0] m_regs [NREG];
  bit m_wr = 0, m_reg = 0;
  int wq_a[$];
  int wq_d[$];

  function automatic logic [NREG*DW-1:0] model_flat();
    logic [NREG*DW-1:0] f;
    for (int i = 0; i < NREG; i++) f[i*DW +: DW] = m_regs[i];
    return f;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push(input string tag, input bit use_b, input logic b);
    exp_t e;
    e.tag = tag; e.regs = model_flat(); e.lat = {m_reg, m_wr};
    e.use_busy = use_b; e.bsy = b;
    sb.push_back(e);
  endtask

  // Monitor: compares queued expectations one time unit after each falling edge
  initial begin
    forever begin
      @(negedge clk); #1;
      while (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        check({e.tag, " regs"}, 64'(reg_flat), 64'(e.regs));
        check({e.tag, " latch"}, 64'(latch_state), 64'(e.lat));
        if (e.use_busy) check({e.tag, " busy"}, 64'(busy), 64'(e.bsy));
      end
    end
  end

  task automatic wr(input int a, input int d);
    wq_a.push_back(a); wq_d.push_back(d);
  endtask

  // Driver: one transaction from the write queue
  task automatic send(input string tag, input bit with_stop, input bit exp_ack);
    bit committed;
    int st;
    @(negedge clk);
    txn_start = 1;
    #1 check({tag, " ack R8"}, 64'(txn_ack), 64'(exp_ack));
    @(negedge clk);
    txn_start = 0;
    foreach (wq_a[k]) begin
      wr_valid = 1; wr_addr = AW'(wq_a[k]); wr_data = DW'(wq_d[k]);
      @(negedge clk);
    end
    wr_valid = 0;
    committed = 0;
    if (with_stop) begin
      txn_stop = 1;
      @(negedge clk);
      txn_stop = 0;
      if (exp_ack) begin
        st = -1;
        foreach (wq_a[k]) begin
          if (wq_a[k] < NREG) begin
            if (m_reg) begin m_regs[wq_a[k]] = DW'(wq_d[k]); committed = 1; end
          end else if (wq_a[k] == NREG) st = wq_d[k];
        end
        if (st == 0) begin m_wr = 0; m_reg = 0; end
        else if (st == 2) m_wr = 1;
        else if (st == 6 && m_wr) m_reg = 1;
      end
      push(tag, exp_ack, committed && busy_len != 0);
    end
    wq_a.delete(); wq_d.delete();
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < NREG; i++) m_regs[i] = '0;
    repeat (3) @(negedge clk);
    push("R1 reset", 1, 0);
    @(negedge clk);
    rst_n = 1;

    wr(2, 8'h11); send("R5 locked write", 1, 1);
    wr(8, 8'h06); send("R3 unlock before arm", 1, 1);
    wr(8, 8'h02); send("R2 arm", 1, 1);
    wr(8, 8'h04); send("R4 unknown code", 1, 1);
    wr(1, 8'h22); send("R5 armed only", 1, 1);
    wr(8, 8'h06); send("R3 unlock", 1, 1);

    wr(3, 8'hA5); wr(5, 8'h5A); wr(3, 8'hC3); send("R5 R7 commit", 1, 1);
    // Busy window: high at k=1..5, low at k=6 after the stop
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk); #1;
      check($sformatf("R7 busy k=%0d", k), 64'(busy), 64'(k < 6));
    end
    wait_idle();

    wr(4, 8'h77); send("R6 open", 0, 1);
    wr(6, 8'h66); send("R6 abort", 1, 1);
    wait_idle();

    wr(9, 8'hFF); wr(15, 8'hFF); send("R9 out of range", 1, 1);

    busy_len = 8'd20;
    wr(0, 8'h10); send("R7 long commit", 1, 1);
    wr(1, 8'h99); send("R8 write while busy", 1, 0);
    wait_idle();

    wr(7, 8'hE7); wr(8, 8'h00); send("R10 mixed", 1, 1);
    wait_idle();

    busy_len = 8'd0;
    wr(8, 8'h02); send("R2 rearm", 1, 1);
    wr(8, 8'h06); send("R3 relock open", 1, 1);
    wr(2, 8'h2B); send("R7 zero length", 1, 1);

    // R9: stray strobe and stop with no transaction open
    @(negedge clk);
    wr_valid = 1; wr_addr = 4'd2; wr_data = 8'h00;
    @(negedge clk);
    wr_valid = 0; txn_stop = 1;
    @(negedge clk);
    txn_stop = 0;
    push("R9 stray strobe", 1, 0);

    wr(8, 8'h00); send("R4 clear", 1, 1);

    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(4 * 200000);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule